// File: doc/BRIEF.md
# Two-Wire Wiper Command Slave

This block is the slave end of a two-wire serial bus that sets a bank of four digitally controlled resistor wipers, each with four stored data registers. It oversamples the clock and data lines with the system clock, finds start and stop conditions, and checks the address byte against a fixed device-type nibble and four strapped address pins. It then takes an instruction byte and, for some opcodes, a third byte. It acknowledges by pulling the data line low through an active-high pull-down enable, and it shifts read data out the same way.

Completed write and transfer transactions leave the block as a one-cycle pulse on a parallel command port after the closing stop. Read transactions select a register through the read-select outputs and serialise the value that the bank returns. The increment/decrement opcode opens a streaming phase. In this phase each bus clock moves the selected wiper one step, up or down, and each step leaves the block as a separate pulse. The register bank, its nonvolatile store and the analog array sit outside the block. The bank reports a store in progress on `busy_i`.

States: `ST_IDLE` (waiting for a start), `ST_ADDR` (address bits), `ST_ADDR_ACK`, `ST_INSTR` (instruction bits), `ST_INSTR_ACK`, `ST_WDATA` (host data bits), `ST_WDATA_ACK`, `ST_RDATA` (slave data bits), `ST_RD_MACK` (host acknowledge), `ST_INCDEC` (step stream), `ST_WAIT_STOP` (transaction complete) and `ST_IGNORE` (discarding until a start). A start moves any state to `ST_ADDR`, and a stop moves any state to `ST_IDLE`. A byte that ends in `ST_ADDR` goes to `ST_ADDR_ACK` on a match and to `ST_IGNORE` otherwise. A byte that ends in `ST_INSTR` goes to `ST_INSTR_ACK` for a known opcode and to `ST_IGNORE` otherwise. The falling clock edge that ends `ST_INSTR_ACK` leads to `ST_WAIT_STOP` for two-byte opcodes, `ST_WDATA` for writes, `ST_RDATA` for reads and `ST_INCDEC` for stepping. `ST_WDATA` leads through `ST_WDATA_ACK` to `ST_WAIT_STOP`. `ST_RDATA` leads through `ST_RD_MACK` to `ST_WAIT_STOP`.

Top module: `potbus_slave`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A start at any point begins a new address phase and drops any command not yet issued.
- R2: Before the first start after reset, clock and data activity produces no pull-down and no command.
- R3: The address byte is acknowledged only when bits 7:4 equal 0101 and bits 3:0 equal `addr_pins_i`. After a mismatch, the rest of the transfer gets no acknowledge and issues no command.
- R4: If `busy_i` is high when the address byte completes, the address is not acknowledged.
- R5: The instruction byte carries the opcode in bits 7:4, the data-register select in bits 3:2 and the wiper select in bits 1:0. The known opcodes are 1001 read wiper, 1010 write wiper, 1011 read data register, 1100 write data register, 1101 register to wiper, 1110 wiper to register, 0001 all registers to wipers, 1000 all wipers to registers and 0010 step. Any other opcode is not acknowledged and issues nothing.
- R6: After a complete two-byte transfer, `cmd_valid_o` is high for exactly one clock after the stop is seen. `cmd_op_o`, `cmd_reg_o` and `cmd_pot_o` carry the instruction fields.
- R7: For opcodes 1010 and 1100 the third byte is acknowledged. Its bits 5:0 appear on `cmd_data_o` with the command issued at the stop, and its bits 7:6 are ignored.
- R8: For opcodes 1001 and 1011 the block drives `rd_wiper_o` (1 for the wiper), `rd_pot_o` and `rd_reg_o`. It shifts out two zero bits and then `rd_data_i`, MSB first, and releases SDA for the host acknowledge. A read issues no command.
- R9: In the step phase, each SCL clock whose falling edge is reached gives one `step_valid_o` pulse at that falling edge. `step_up_o` is the SDA level seen at the rising edge. A clock cut short by a stop gives no step, and the stop issues no command.
- R10: A stop before all the bytes an opcode needs have arrived issues no command.
- R11: `sda_pull_o` is high only during a slave acknowledge or while a 0 read bit is driven.
- R12: After reset, `sda_pull_o`, `cmd_valid_o` and `step_valid_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_pins_i | input | 4 | Strapped low address nibble |
| busy_i | input | 1 | Nonvolatile store in progress |
| rd_data_i | input | 6 | Value returned by the register bank for the read selection |
| sda_pull_o | output | 1 | Pull-down enable for the data line |
| cmd_valid_o | output | 1 | One-cycle command pulse |
| cmd_op_o | output | 4 | Opcode of the command |
| cmd_reg_o | output | 2 | Data-register select |
| cmd_pot_o | output | 2 | Wiper select (also the step target) |
| cmd_data_o | output | 6 | Write value |
| step_valid_o | output | 1 | One-cycle wiper step pulse |
| step_up_o | output | 1 | Step direction, 1 = up |
| rd_wiper_o | output | 1 | Read source: 1 wiper, 0 data register |
| rd_pot_o | output | 2 | Read wiper select |
| rd_reg_o | output | 2 | Read data-register select |

## Verification
The bench aims at the paths where a transfer must be dropped: a wrong type nibble, a wrong strapped address, a busy store, an unknown opcode, a write cut short by a stop, and a repeated start after a complete two-byte instruction. A design that got these wrong would issue a stray command or acknowledge a byte the host should see refused. It checks that the upper two bits of a write byte are masked, and that read bits reach the line MSB first behind two zeros. It also drives a step stream that ends in a stop. A design that counted the final, stop-carrying clock as a step would leave the wiper one position low.

// File: rtl/potbus_pkg.sv
package potbus_pkg;
    localparam int BYTE_W = 8;
    localparam int VAL_W  = 6;
    localparam int SEL_W  = 2;
    localparam int OPC_W  = 4;
    localparam int PIN_W  = 4;

    localparam logic [OPC_W-1:0] DEV_TYPE     = 4'b0101;
    localparam logic [OPC_W-1:0] OPC_RD_WIPER = 4'b1001;
    localparam logic [OPC_W-1:0] OPC_WR_WIPER = 4'b1010;
    localparam logic [OPC_W-1:0] OPC_RD_DREG  = 4'b1011;
    localparam logic [OPC_W-1:0] OPC_WR_DREG  = 4'b1100;
    localparam logic [OPC_W-1:0] OPC_DREG2W   = 4'b1101;
    localparam logic [OPC_W-1:0] OPC_W2DREG   = 4'b1110;
    localparam logic [OPC_W-1:0] OPC_ALL_D2W  = 4'b0001;
    localparam logic [OPC_W-1:0] OPC_ALL_W2D  = 4'b1000;
    localparam logic [OPC_W-1:0] OPC_STEP     = 4'b0010;

    typedef enum logic [2:0] {
        CLS_BAD,
        CLS_SHORT,
        CLS_WRITE,
        CLS_READ,
        CLS_STEP
    } op_class_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_INSTR,
        ST_INSTR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RD_MACK,
        ST_INCDEC,
        ST_WAIT_STOP,
        ST_IGNORE
    } state_e;
endpackage

// File: rtl/potbus_sync.sv
module potbus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_lvl,
    output logic start_ev,
    output logic stop_ev
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;
    logic              scl_now;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[LAST-1:0], scl_i};
            sda_pipe <= {sda_pipe[LAST-1:0], sda_i};
            scl_prev <= scl_pipe[LAST];
            sda_prev <= sda_pipe[LAST];
        end
    end

    assign scl_now  = scl_pipe[LAST];
    assign sda_lvl  = sda_pipe[LAST];
    assign scl_rise = scl_now & ~scl_prev;
    assign scl_fall = ~scl_now & scl_prev;
    assign start_ev = scl_now & scl_prev & sda_prev & ~sda_lvl;
    assign stop_ev  = scl_now & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/potbus_rxbyte.sv
module potbus_rxbyte #(
    parameter int BITS  = 8,
    parameter int CNT_W = $clog2(BITS + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             sample,
    input  logic             bit_i,
    output logic [BITS-1:0]  data_o,
    output logic [CNT_W-1:0] cnt_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o <= '0;
            cnt_o  <= '0;
        end else if (clr) begin
            cnt_o <= '0;
        end else if (sample) begin
            data_o <= {data_o[BITS-2:0], bit_i};
            if (cnt_o != '1) begin
                cnt_o <= cnt_o + 1'b1;
            end
        end
    end
endmodule

// File: rtl/potbus_opdec.sv
module potbus_opdec
    import potbus_pkg::*;
(
    input  logic [OPC_W-1:0] opc_i,
    output op_class_e        cls_o
);
    always_comb begin
        case (opc_i)
            OPC_DREG2W, OPC_W2DREG, OPC_ALL_D2W, OPC_ALL_W2D: cls_o = CLS_SHORT;
            OPC_WR_WIPER, OPC_WR_DREG:                        cls_o = CLS_WRITE;
            OPC_RD_WIPER, OPC_RD_DREG:                        cls_o = CLS_READ;
            OPC_STEP:                                         cls_o = CLS_STEP;
            default:                                          cls_o = CLS_BAD;
        endcase
    end
endmodule

// File: rtl/potbus_slave.sv
module potbus_slave
    import potbus_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [PIN_W-1:0] addr_pins_i,
    input  logic             busy_i,
    input  logic [VAL_W-1:0] rd_data_i,
    output logic             sda_pull_o,
    output logic             cmd_valid_o,
    output logic [OPC_W-1:0] cmd_op_o,
    output logic [SEL_W-1:0] cmd_reg_o,
    output logic [SEL_W-1:0] cmd_pot_o,
    output logic [VAL_W-1:0] cmd_data_o,
    output logic             step_valid_o,
    output logic             step_up_o,
    output logic             rd_wiper_o,
    output logic [SEL_W-1:0] rd_pot_o,
    output logic [SEL_W-1:0] rd_reg_o
);
    localparam int CNT_W = $clog2(BYTE_W + 2);
    localparam int PAD_W = BYTE_W - VAL_W;

    state_e state_q, state_d;

    logic scl_rise, scl_fall, sda_lvl, start_ev, stop_ev;
    logic [BYTE_W-1:0] rx_byte;
    logic [CNT_W-1:0]  bit_cnt;
    logic in_ack, cnt_clr, byte_done, addr_hit;
    op_class_e rx_cls, op_cls;

    logic [BYTE_W-1:0] tx_q;
    logic [OPC_W-1:0]  op_q;
    logic [SEL_W-1:0]  reg_q, pot_q;
    logic [VAL_W-1:0]  data_q;
    logic              pend_cmd_q, cmd_valid_q;
    logic              step_valid_q, step_up_q, stp_pend_q, stp_dir_q;

    potbus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .sda_lvl  (sda_lvl),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    potbus_rxbyte #(.BITS(BYTE_W), .CNT_W(CNT_W)) u_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cnt_clr),
        .sample (scl_rise),
        .bit_i  (sda_lvl),
        .data_o (rx_byte),
        .cnt_o  (bit_cnt)
    );

    potbus_opdec u_dec_rx (.opc_i(rx_byte[BYTE_W-1 -: OPC_W]), .cls_o(rx_cls));
    potbus_opdec u_dec_op (.opc_i(op_q), .cls_o(op_cls));

    assign in_ack    = (state_q == ST_ADDR_ACK) || (state_q == ST_INSTR_ACK) ||
                       (state_q == ST_WDATA_ACK) || (state_q == ST_RD_MACK);
    assign cnt_clr   = start_ev | (scl_fall & in_ack);
    assign byte_done = scl_fall && (bit_cnt == CNT_W'(BYTE_W));
    assign addr_hit  = (rx_byte[BYTE_W-1 -: OPC_W] == DEV_TYPE) &&
                       (rx_byte[PIN_W-1:0] == addr_pins_i) && !busy_i;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (start_ev) begin
            state_d = ST_ADDR;
        end else if (stop_ev) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_IGNORE, ST_WAIT_STOP, ST_INCDEC: state_d = state_q;
                ST_ADDR: begin
                    if (byte_done) state_d = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) state_d = ST_INSTR;
                end
                ST_INSTR: begin
                    if (byte_done) state_d = (rx_cls == CLS_BAD) ? ST_IGNORE : ST_INSTR_ACK;
                end
                ST_INSTR_ACK: begin
                    if (scl_fall) begin
                        unique case (op_cls)
                            CLS_SHORT: state_d = ST_WAIT_STOP;
                            CLS_WRITE: state_d = ST_WDATA;
                            CLS_READ:  state_d = ST_RDATA;
                            CLS_STEP:  state_d = ST_INCDEC;
                            default:   state_d = ST_IGNORE;
                        endcase
                    end
                end
                ST_WDATA: begin
                    if (byte_done) state_d = ST_WDATA_ACK;
                end
                ST_WDATA_ACK: begin
                    if (scl_fall) state_d = ST_WAIT_STOP;
                end
                ST_RDATA: begin
                    if (byte_done) state_d = ST_RD_MACK;
                end
                ST_RD_MACK: begin
                    if (scl_fall) state_d = ST_WAIT_STOP;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q         <= '1;
            op_q         <= '0;
            reg_q        <= '0;
            pot_q        <= '0;
            data_q       <= '0;
            pend_cmd_q   <= 1'b0;
            cmd_valid_q  <= 1'b0;
            step_valid_q <= 1'b0;
            step_up_q    <= 1'b0;
            stp_pend_q   <= 1'b0;
            stp_dir_q    <= 1'b0;
        end else begin
            cmd_valid_q  <= 1'b0;
            step_valid_q <= 1'b0;
            if (state_q != ST_INCDEC || start_ev || stop_ev) begin
                stp_pend_q <= 1'b0;
            end
            if (start_ev) begin
                pend_cmd_q <= 1'b0;
            end else if (stop_ev) begin
                cmd_valid_q <= (state_q == ST_WAIT_STOP) && pend_cmd_q;
                pend_cmd_q  <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_INSTR: begin
                        if (byte_done) begin
                            op_q  <= rx_byte[BYTE_W-1 -: OPC_W];
                            reg_q <= rx_byte[2*SEL_W-1 -: SEL_W];
                            pot_q <= rx_byte[SEL_W-1:0];
                        end
                    end
                    ST_INSTR_ACK: begin
                        if (scl_fall) begin
                            if (op_cls == CLS_SHORT) pend_cmd_q <= 1'b1;
                            if (op_cls == CLS_READ)  tx_q <= {{PAD_W{1'b0}}, rd_data_i};
                        end
                    end
                    ST_RDATA: begin
                        if (scl_fall && !byte_done) tx_q <= {tx_q[BYTE_W-2:0], 1'b1};
                    end
                    ST_WDATA: begin
                        if (byte_done) data_q <= rx_byte[VAL_W-1:0];
                    end
                    ST_WDATA_ACK: begin
                        if (scl_fall) pend_cmd_q <= 1'b1;
                    end
                    ST_INCDEC: begin
                        if (scl_rise) begin
                            stp_pend_q <= 1'b1;
                            stp_dir_q  <= sda_lvl;
                        end else if (scl_fall && stp_pend_q) begin
                            stp_pend_q   <= 1'b0;
                            step_valid_q <= 1'b1;
                            step_up_q    <= stp_dir_q;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (state_q)
            ST_ADDR_ACK, ST_INSTR_ACK, ST_WDATA_ACK: sda_pull_o = 1'b1;
            ST_RDATA:                                sda_pull_o = ~tx_q[BYTE_W-1];
            default:                                 sda_pull_o = 1'b0;
        endcase
    end

    assign cmd_valid_o  = cmd_valid_q;
    assign cmd_op_o     = op_q;
    assign cmd_reg_o    = reg_q;
    assign cmd_pot_o    = pot_q;
    assign cmd_data_o   = data_q;
    assign step_valid_o = step_valid_q;
    assign step_up_o    = step_up_q;
    assign rd_wiper_o   = (op_q == OPC_RD_WIPER);
    assign rd_pot_o     = pot_q;
    assign rd_reg_o     = reg_q;
endmodule

// File: rtl/potbus_slave_chk.sv
module potbus_slave_chk
    import potbus_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   busy_i,
    input logic   sda_pull_o,
    input logic   cmd_valid_o,
    input logic   step_valid_o,
    input state_e state_q
);
    a_r4_busy_blocks_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR_ACK && $past(state_q) == ST_ADDR) |-> !$past(busy_i));

    a_r6_cmd_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o);

    a_r10_cmd_only_complete: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> $past(state_q) == ST_WAIT_STOP);

    a_r9_step_in_stream: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid_o |-> $past(state_q) == ST_INCDEC);

    a_r9_step_not_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        !(step_valid_o && cmd_valid_o));

    a_r11_released_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE || state_q == ST_IGNORE || state_q == ST_WAIT_STOP ||
         state_q == ST_INCDEC) |-> !sda_pull_o);
endmodule

bind potbus_slave potbus_slave_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy_i       (busy_i),
    .sda_pull_o   (sda_pull_o),
    .cmd_valid_o  (cmd_valid_o),
    .step_valid_o (step_valid_o),
    .state_q      (state_q)
);

// File: tb/potbus_slave_bench.sv
`timescale 1ns/1ps
module potbus_slave_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic busy = 1'b0;
    logic [3:0] pins = 4'b1010;
    logic sda_pull, cmd_valid, step_valid, step_up, rd_wiper;
    logic [3:0] cmd_op;
    logic [1:0] cmd_reg, cmd_pot, rd_pot, rd_reg;
    logic [5:0] cmd_data, rd_data;
    logic bus_sda;

    int tests = 0;
    int fails = 0;
    int cmd_cnt = 0;
    int up_cnt = 0;
    int dn_cnt = 0;
    logic [3:0] cap_op;
    logic [1:0] cap_reg, cap_pot, step_pot;
    logic [5:0] cap_data;

    always #5 clk = ~clk;

    assign bus_sda = sda_m & ~sda_pull;
    assign rd_data = rd_wiper ? (6'h28 | {4'b0, rd_pot}) : {2'b01, rd_pot, rd_reg};

    potbus_slave u_potbus_slave (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl_m),
        .sda_i        (bus_sda),
        .addr_pins_i  (pins),
        .busy_i       (busy),
        .rd_data_i    (rd_data),
        .sda_pull_o   (sda_pull),
        .cmd_valid_o  (cmd_valid),
        .cmd_op_o     (cmd_op),
        .cmd_reg_o    (cmd_reg),
        .cmd_pot_o    (cmd_pot),
        .cmd_data_o   (cmd_data),
        .step_valid_o (step_valid),
        .step_up_o    (step_up),
        .rd_wiper_o   (rd_wiper),
        .rd_pot_o     (rd_pot),
        .rd_reg_o     (rd_reg)
    );

    always @(negedge clk) begin
        if (cmd_valid) begin
            cmd_cnt  <= cmd_cnt + 1;
            cap_op   <= cmd_op;
            cap_reg  <= cmd_reg;
            cap_pot  <= cmd_pot;
            cap_data <= cmd_data;
        end
        if (step_valid) begin
            if (step_up) up_cnt <= up_cnt + 1;
            else         dn_cnt <= dn_cnt + 1;
            step_pot <= cmd_pot;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_bit(input logic b, output logic seen);
        wait_clk(5); sda_m = b;
        wait_clk(5); scl_m = 1'b1;
        wait_clk(5); seen = bus_sda;
        wait_clk(5); scl_m = 1'b0;
    endtask

    task automatic bus_start();
        wait_clk(5); sda_m = 1'b1;
        wait_clk(5); scl_m = 1'b1;
        wait_clk(10); sda_m = 1'b0;
        wait_clk(10); scl_m = 1'b0;
    endtask

    task automatic bus_stop();
        wait_clk(5); sda_m = 1'b0;
        wait_clk(5); scl_m = 1'b1;
        wait_clk(10); sda_m = 1'b1;
        wait_clk(10);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int k = 7; k >= 0; k--) bus_bit(b[k], s);
        bus_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic read_byte(output logic [7:0] v);
        logic s;
        for (int k = 7; k >= 0; k--) begin
            bus_bit(1'b1, s);
            v[k] = s;
        end
        bus_bit(1'b0, s);
    endtask

    // {addr, instr, data, len, acks(addr,instr,data), cmd}
    localparam int NV = 10;
    localparam logic [29:0] VEC [NV] = '{
        {8'h5A, 8'hD6, 8'h00, 2'd2, 3'b110, 1'b1},
        {8'h5A, 8'hAB, 8'h2D, 2'd3, 3'b111, 1'b1},
        {8'h5A, 8'hC5, 8'hFF, 2'd3, 3'b111, 1'b1},
        {8'h5B, 8'hA0, 8'h11, 2'd3, 3'b000, 1'b0},
        {8'h7A, 8'hD6, 8'h00, 2'd2, 3'b000, 1'b0},
        {8'h5A, 8'h30, 8'h00, 2'd2, 3'b100, 1'b0},
        {8'h5A, 8'h14, 8'h00, 2'd2, 3'b110, 1'b1},
        {8'h5A, 8'h88, 8'h00, 2'd2, 3'b110, 1'b1},
        {8'h5A, 8'hE7, 8'h00, 2'd2, 3'b110, 1'b1},
        {8'h5A, 8'hA1, 8'h00, 2'd2, 3'b110, 1'b0}
    };

    initial begin
        wait_clk(100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic a0, a1, a2, s;
        logic [7:0] rv;
        int c0;
        wait_clk(10);
        check(sda_pull == 1'b0, "R12 pull after reset", sda_pull, 0);
        check(cmd_valid == 1'b0, "R12 cmd after reset", cmd_valid, 0);
        check(step_valid == 1'b0, "R12 step after reset", step_valid, 0);
        rst_n = 1'b1;
        wait_clk(5);

        // R2: a matching address byte with no start before it
        wait_clk(5); scl_m = 1'b0;
        send_byte(8'h5A, a0);
        check(a0 == 1'b0, "R2 no ack before start", a0, 0);
        bus_stop();

        // table of transactions: R3 R5 R6 R7 R10
        for (int v = 0; v < NV; v++) begin
            logic [29:0] e;
            e = VEC[v];
            c0 = cmd_cnt;
            a0 = 0; a1 = 0; a2 = 0;
            bus_start();
            send_byte(e[29:22], a0);
            if (e[5:4] >= 2) send_byte(e[21:14], a1);
            if (e[5:4] == 3) send_byte(e[13:6], a2);
            bus_stop();
            wait_clk(5);
            check({a0, a1, a2} == e[3:1], "R3/R5 ack pattern", {a0, a1, a2}, e[3:1]);
            check((cmd_cnt - c0) == int'(e[0]), "R6/R10 command count", cmd_cnt - c0, e[0]);
            if (e[0]) begin
                check({cap_op, cap_reg, cap_pot} == e[21:14], "R6 command fields",
                      {cap_op, cap_reg, cap_pot}, e[21:14]);
                if (e[5:4] == 3)
                    check(cap_data == e[11:6], "R7 write value", cap_data, e[11:6]);
            end
        end

        // R4: busy store refuses the address
        busy = 1'b1;
        bus_start();
        send_byte(8'h5A, a0);
        bus_stop();
        busy = 1'b0;
        check(a0 == 1'b0, "R4 no ack while busy", a0, 0);

        // R8/R11: read wiper 2 then data register 1 of wiper 3
        c0 = cmd_cnt;
        bus_start();
        send_byte(8'h5A, a0);
        send_byte(8'h92, a1);
        read_byte(rv);
        bus_stop();
        check(rv == 8'h2A, "R8 read wiper", rv, 8'h2A);
        bus_start();
        send_byte(8'h5A, a0);
        send_byte(8'hB7, a1);
        read_byte(rv);
        bus_stop();
        wait_clk(5);
        check(rv == 8'h1D, "R8 R11 read data register", rv, 8'h1D);
        check(cmd_cnt == c0, "R8 read issues no command", cmd_cnt - c0, 0);

        // R9: three up, two down, stop clock gives none
        c0 = cmd_cnt;
        bus_start();
        send_byte(8'h5A, a0);
        send_byte(8'h23, a1);
        bus_bit(1'b1, s); bus_bit(1'b1, s); bus_bit(1'b1, s);
        bus_bit(1'b0, s); bus_bit(1'b0, s);
        bus_stop();
        wait_clk(5);
        check(up_cnt == 3, "R9 up steps", up_cnt, 3);
        check(dn_cnt == 2, "R9 down steps", dn_cnt, 2);
        check(step_pot == 2'd3, "R9 step target", step_pot, 3);
        check(cmd_cnt == c0, "R9 no command at stop", cmd_cnt - c0, 0);

        // R1: repeated start drops the pending transfer command
        c0 = cmd_cnt;
        bus_start();
        send_byte(8'h5A, a0);
        send_byte(8'hD6, a1);
        bus_start();
        send_byte(8'h5A, a0);
        send_byte(8'h14, a1);
        bus_stop();
        wait_clk(5);
        check(cmd_cnt - c0 == 1, "R1 one command after restart", cmd_cnt - c0, 1);
        check(cap_op == 4'h1, "R1 surviving opcode", cap_op, 1);
        check(sda_pull == 1'b0, "R11 released after stop", sda_pull, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule